// File: doc/BRIEF.md
# Oscillator Fault Flag Controller

This block turns raw oscillator fault signals into interrupt flags that software can read and clear. It watches four conditions: a fault on the low-frequency crystal, a fault on the high-frequency crystal, an open circuit on the internal oscillator's bias resistor, and a short circuit on that same resistor. Each raw condition passes through a synchronizer and then drives a sticky flag. A flag stays set for as long as its fault lasts. Software can clear a flag only after the fault has gone away.

The controller also picks the clock source. When the source chosen by the user has a raised fault flag, the block replaces that choice with a safe fallback source. It hands the user's choice back in the same cycle that the matching flag is cleared.

A resistor short is the most serious fault, so it also sends a one-cycle reset request to the device. Its flag is kept through that reset. Only a power-on event or a dedicated clear strobe can remove it.

Top module: `osc_fault_ctrl`

## Requirements
- R1: Once `por_n` and `rst_n` are released, all of the following hold: every bit of `flags` is 0, `reset_req` is 0, `override` is 0 and `eff_src` equals `user_src`.
- R2: Each raw fault input goes through a synchronizer of `SYNC_STAGES` flops (default 2). A raw fault that is first sampled high at rising edge n becomes visible in `flags` after edge n+`SYNC_STAGES`. The flag bit positions are: bit 0 low-frequency crystal, bit 1 high-frequency crystal, bit 2 resistor open, bit 3 resistor short.
- R3: Flags 0 to 2 stay set for as long as their synchronized fault is high. A `flag_clr[i]` strobe (bit i matches flag i) on an edge where that fault is still high is ignored, because setting wins over clearing.
- R4: A flag 0 to 2 stays set after its fault goes away. It clears on the edge where `flag_clr[i]` is high and the synchronized fault is low.
- R5: The resistor-short fault sets `flags[3]` with the same timing as R2. `reset_req` is high for exactly the one cycle that follows the edge where `flags[3]` rises.
- R6: `flags[3]` ignores `flag_clr` and `rst_n`. It is cleared only by `por_n` low, or by `rshort_clr` on an edge where the synchronized short fault is low.
- R7: `rst_n` low clears flags 0 to 2 and all synchronizer stages. `por_n` low clears everything.
- R8: The source codes are 0 = low-frequency crystal, 1 = high-frequency crystal, 2 = internal oscillator, 3 = safe fallback. `override` is high when `user_src` selects source 0 and flag 0 is set, or source 1 and flag 1 is set, or source 2 and flag 2 or flag 3 is set. While `override` is high, `eff_src` is 3.
- R9: While `override` is low, `eff_src` equals `user_src`. The return to the user's selection happens in the same cycle that the blocking flag clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | System reset, active low, asynchronous |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| raw_lf_fault | input | 1 | Raw low-frequency crystal fault |
| raw_hf_fault | input | 1 | Raw high-frequency crystal fault |
| raw_ropen_fault | input | 1 | Raw bias-resistor open fault |
| raw_rshort_fault | input | 1 | Raw bias-resistor short fault |
| flag_clr | input | 3 | Clear strobes for flags 0 to 2 |
| rshort_clr | input | 1 | Dedicated clear strobe for the short flag |
| user_src | input | 2 | Clock source chosen by software |
| flags | output | 4 | Sticky fault flags |
| override | output | 1 | Fallback source is forced |
| eff_src | output | 2 | Clock source actually selected |
| reset_req | output | 1 | One-cycle device reset request |

## Verification
The bench issues a clear strobe in the same cycle that a fault is still synchronized high. A design that let the clear win would drop the flag while the fault persists. It also pulses `rst_n` and every `flag_clr` bit while the short flag is set. A design that routed the short flag through the ordinary reset or clear path would lose a flag that must survive the reset it caused. Switching `user_src` between a faulted and a healthy source catches an override that ignores the user's choice. Checking the cycle right after each clear catches a fallback that releases late or early. The edge-exact timing of flag rises catches a synchronizer with the wrong depth.

// File: rtl/osc_fault_pkg.sv
package osc_fault_pkg;
   localparam int FLT_N      = 4;
   localparam int CLR_N      = 3;
   localparam int FLT_LF     = 0;
   localparam int FLT_HF     = 1;
   localparam int FLT_ROPEN  = 2;
   localparam int FLT_RSHORT = 3;
   typedef logic [FLT_N-1:0] flt_vec_t;
endpackage

// File: rtl/ofc_sync.sv
module ofc_sync #(
   parameter int W      = 4,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   if (STAGES < 2) begin : g_bad_depth
      $error("ofc_sync: STAGES must be at least 2");
   end
   if (W < 1) begin : g_bad_width
      $error("ofc_sync: W must be positive");
   end

   logic [W-1:0] stg [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[0] <= '0;
            else        stg[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) stg[s] <= '0;
            else        stg[s] <= stg[s-1];
         end
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/ofc_sticky_flag.sv
module ofc_sticky_flag #(
   parameter bit PERSIST = 1'b0
) (
   input  logic clk,
   input  logic sys_rst_n,
   input  logic por_n,
   input  logic fault_s,
   input  logic clr,
   output logic flag
);
   logic flag_d;
   logic rst_eff_n;

   // set dominates clear
   assign flag_d = fault_s | (flag & ~clr);

   if (PERSIST) begin : g_persist
      assign rst_eff_n = por_n;
      logic unused_sys;
      assign unused_sys = sys_rst_n;

      always_ff @(posedge clk or negedge por_n) begin
         if (!por_n) flag <= 1'b0;
         else        flag <= flag_d;
      end

      // R6
      short_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
         (flag && !clr) |=> flag);
   end else begin : g_plain
      assign rst_eff_n = sys_rst_n & por_n;

      always_ff @(posedge clk or negedge rst_eff_n) begin
         if (!rst_eff_n) flag <= 1'b0;
         else            flag <= flag_d;
      end
   end

   // R3
   keep_while_fault_chk: assert property (@(posedge clk) disable iff (!rst_eff_n)
      fault_s |=> flag);

   // R4
   clear_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_eff_n)
      (flag && clr && !fault_s) |=> !flag);
endmodule

// File: rtl/ofc_src_override.sv
module ofc_src_override
   import osc_fault_pkg::*;
#(
   parameter int SEL_W    = 2,
   parameter int SRC_LF   = 0,
   parameter int SRC_HF   = 1,
   parameter int SRC_INT  = 2,
   parameter int SRC_SAFE = 3
) (
   input  flt_vec_t         flags,
   input  logic [SEL_W-1:0] user_src,
   output logic             override,
   output logic [SEL_W-1:0] eff_src
);
   localparam logic [SEL_W-1:0] C_LF   = SEL_W'(SRC_LF);
   localparam logic [SEL_W-1:0] C_HF   = SEL_W'(SRC_HF);
   localparam logic [SEL_W-1:0] C_INT  = SEL_W'(SRC_INT);
   localparam logic [SEL_W-1:0] C_SAFE = SEL_W'(SRC_SAFE);

   logic hit_lf, hit_hf, hit_int;

   always_comb begin
      hit_lf   = (user_src == C_LF)  && flags[FLT_LF];
      hit_hf   = (user_src == C_HF)  && flags[FLT_HF];
      hit_int  = (user_src == C_INT) && (flags[FLT_ROPEN] || flags[FLT_RSHORT]);
      override = hit_lf | hit_hf | hit_int;
      eff_src  = override ? C_SAFE : user_src;
   end
endmodule

// File: rtl/osc_fault_ctrl.sv
module osc_fault_ctrl
   import osc_fault_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = 2,
   parameter int SRC_LF      = 0,
   parameter int SRC_HF      = 1,
   parameter int SRC_INT     = 2,
   parameter int SRC_SAFE    = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             por_n,
   input  logic             raw_lf_fault,
   input  logic             raw_hf_fault,
   input  logic             raw_ropen_fault,
   input  logic             raw_rshort_fault,
   input  logic [CLR_N-1:0] flag_clr,
   input  logic             rshort_clr,
   input  logic [SEL_W-1:0] user_src,
   output logic [FLT_N-1:0] flags,
   output logic             override,
   output logic [SEL_W-1:0] eff_src,
   output logic             reset_req
);
   localparam int SRC_MAX = (1 << SEL_W) - 1;

   if (SEL_W < 2) begin : g_bad_sel
      $error("osc_fault_ctrl: SEL_W must be at least 2");
   end
   if (SRC_LF > SRC_MAX || SRC_HF > SRC_MAX || SRC_INT > SRC_MAX || SRC_SAFE > SRC_MAX) begin : g_bad_code
      $error("osc_fault_ctrl: source code does not fit SEL_W");
   end
   if (SRC_SAFE == SRC_LF || SRC_SAFE == SRC_HF || SRC_SAFE == SRC_INT) begin : g_bad_safe
      $error("osc_fault_ctrl: fallback code must differ from monitored sources");
   end
   if (SRC_LF == SRC_HF || SRC_LF == SRC_INT || SRC_HF == SRC_INT) begin : g_bad_dup
      $error("osc_fault_ctrl: monitored source codes must be distinct");
   end

   logic     sys_clr_n;
   flt_vec_t raw_vec;
   flt_vec_t sync_vec;
   flt_vec_t clr_vec;

   assign sys_clr_n = rst_n & por_n;
   assign raw_vec   = {raw_rshort_fault, raw_ropen_fault, raw_hf_fault, raw_lf_fault};
   assign clr_vec   = {rshort_clr, flag_clr};

   ofc_sync #(.W(FLT_N), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (sys_clr_n),
      .d     (raw_vec),
      .q     (sync_vec)
   );

   for (genvar i = 0; i < FLT_N; i++) begin : g_flag
      ofc_sticky_flag #(.PERSIST(i == FLT_RSHORT)) u_flag (
         .clk       (clk),
         .sys_rst_n (rst_n),
         .por_n     (por_n),
         .fault_s   (sync_vec[i]),
         .clr       (clr_vec[i]),
         .flag      (flags[i])
      );
   end

   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n) reset_req <= 1'b0;
      else        reset_req <= sync_vec[FLT_RSHORT] & ~flags[FLT_RSHORT];
   end

   ofc_src_override #(
      .SEL_W(SEL_W), .SRC_LF(SRC_LF), .SRC_HF(SRC_HF),
      .SRC_INT(SRC_INT), .SRC_SAFE(SRC_SAFE)
   ) u_ovr (
      .flags    (flags),
      .user_src (user_src),
      .override (override),
      .eff_src  (eff_src)
   );

   // R5
   rst_req_pulse_chk: assert property (@(posedge clk) disable iff (!por_n)
      reset_req |=> !reset_req);

   // R5
   rst_req_flag_chk: assert property (@(posedge clk) disable iff (!por_n)
      reset_req |-> flags[FLT_RSHORT]);

   // R8
   override_sel_chk: assert property (@(posedge clk) disable iff (!por_n)
      override |-> (eff_src == SEL_W'(SRC_SAFE)));

   // R7
   sys_rst_clear_chk: assert property (@(posedge clk) disable iff (!por_n)
      (!rst_n) |-> (flags[CLR_N-1:0] == '0));
endmodule

// File: tb/tb_osc_fault_ctrl.sv
module tb_osc_fault_ctrl;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic por_n = 1'b0;
   logic raw_lf = 1'b0, raw_hf = 1'b0, raw_ro = 1'b0, raw_rs = 1'b0;
   logic [2:0] flag_clr = '0;
   logic rshort_clr = 1'b0;
   logic [1:0] user_src = '0;
   logic [3:0] flags;
   logic override;
   logic [1:0] eff_src;
   logic reset_req;

   int errors = 0;
   int checks = 0;
   int cyc = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   osc_fault_ctrl dut (
      .clk(clk), .rst_n(rst_n), .por_n(por_n),
      .raw_lf_fault(raw_lf), .raw_hf_fault(raw_hf),
      .raw_ropen_fault(raw_ro), .raw_rshort_fault(raw_rs),
      .flag_clr(flag_clr), .rshort_clr(rshort_clr), .user_src(user_src),
      .flags(flags), .override(override), .eff_src(eff_src), .reset_req(reset_req)
   );

   // behavioural reference
   logic [3:0] hist[$];
   logic [3:0] m_flag = '0;
   logic       m_rr = 1'b0;

   task automatic refill();
      hist.delete();
      for (int k = 0; k < 2; k++) hist.push_back(4'b0);
   endtask

   always @(posedge clk or negedge por_n or negedge rst_n) begin
      logic [3:0] s;
      if (!por_n) begin
         m_flag = '0; m_rr = 1'b0; refill();
      end else if (!rst_n) begin
         m_flag[2:0] = '0; m_rr = 1'b0; refill();
      end else begin
         s = hist.pop_front();
         hist.push_back({raw_rs, raw_ro, raw_hf, raw_lf});
         m_rr = s[3] & ~m_flag[3];
         for (int i = 0; i < 3; i++) m_flag[i] = s[i] | (m_flag[i] & ~flag_clr[i]);
         m_flag[3] = s[3] | (m_flag[3] & ~rshort_clr);
      end
   end

   function automatic logic exp_ovr(logic [3:0] f, logic [1:0] us);
      return (us == 2'd0 && f[0]) || (us == 2'd1 && f[1]) || (us == 2'd2 && (f[2] || f[3]));
   endfunction

   task automatic chk(string req, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
      end
   endtask

   // per-cycle comparison against the model
   always @(negedge clk) begin
      cyc++;
      if (cyc > 2) begin
         for (int i = 0; i < 3; i++) chk("R3 flag", int'(flags[i]), int'(m_flag[i]));
         chk("R6 short flag", int'(flags[3]), int'(m_flag[3]));
         chk("R5 reset_req", int'(reset_req), int'(m_rr));
         chk("R8 override", int'(override), int'(exp_ovr(m_flag, user_src)));
         chk("R9 eff_src", int'(eff_src),
             exp_ovr(m_flag, user_src) ? 3 : int'(user_src));
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      finish_run();
   end

   task automatic step(int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   initial begin
      step(3);
      por_n = 1'b1; rst_n = 1'b1;
      step(2);
      // R1
      chk("R1 flags", int'(flags), 0);
      chk("R1 reset_req", int'(reset_req), 0);
      chk("R1 eff_src", int'(eff_src), int'(user_src));

      // R2 timing and R3 set-wins
      user_src = 2'd0;
      raw_lf = 1'b1;
      step(2);
      chk("R2 flag early", int'(flags[0]), 0);
      step(1);
      chk("R2 flag set", int'(flags[0]), 1);
      chk("R8 override lf", int'(eff_src), 3);
      flag_clr = 3'b001;
      step(1);
      flag_clr = '0;
      chk("R3 clear ignored", int'(flags[0]), 1);
      raw_lf = 1'b0;
      step(4);
      chk("R4 flag sticks", int'(flags[0]), 1);
      flag_clr = 3'b001;
      step(1);
      flag_clr = '0;
      chk("R4 flag cleared", int'(flags[0]), 0);
      chk("R9 user back", int'(eff_src), 0);

      // R8 selection dependence
      raw_hf = 1'b1;
      step(4);
      chk("R8 hf not selected", int'(override), 0);
      user_src = 2'd1;
      #1;
      chk("R8 hf selected", int'(eff_src), 3);
      user_src = 2'd3;
      #1;
      chk("R9 safe source passes", int'(eff_src), 3);
      raw_hf = 1'b0;
      user_src = 2'd2;
      raw_ro = 1'b1;
      step(4);
      chk("R8 open override", int'(override), 1);
      raw_ro = 1'b0;
      step(4);
      flag_clr = 3'b110;
      step(1);
      flag_clr = '0;
      chk("R9 open cleared", int'(eff_src), 2);

      // R5 / R6 / R7
      raw_lf = 1'b1;
      raw_rs = 1'b1;
      step(3);
      chk("R5 short flag", int'(flags[3]), 1);
      chk("R5 reset pulse", int'(reset_req), 1);
      step(1);
      chk("R5 pulse ends", int'(reset_req), 0);
      flag_clr = 3'b111; rshort_clr = 1'b1;
      step(2);
      flag_clr = '0; rshort_clr = 1'b0;
      chk("R6 clear while fault", int'(flags[3]), 1);
      raw_rs = 1'b0;
      step(1);
      rst_n = 1'b0;
      step(2);
      chk("R7 plain flags reset", int'(flags[2:0]), 0);
      chk("R6 short survives rst", int'(flags[3]), 1);
      chk("R8 short override", int'(eff_src), 3);
      rst_n = 1'b1;
      raw_lf = 1'b0;
      step(4);
      flag_clr = 3'b111;
      step(1);
      flag_clr = '0;
      chk("R6 short ignores flag_clr", int'(flags[3]), 1);
      rshort_clr = 1'b1;
      step(1);
      rshort_clr = 1'b0;
      chk("R6 short cleared", int'(flags[3]), 0);
      raw_rs = 1'b1;
      step(4);
      raw_rs = 1'b0;
      por_n = 1'b0;
      step(2);
      chk("R7 por clears short", int'(flags[3]), 0);
      por_n = 1'b1;
      step(4);

      // mixed random traffic
      for (int n = 0; n < 600; n++) begin
         raw_lf = ($urandom % 4) == 0;
         raw_hf = ($urandom % 5) == 0;
         raw_ro = ($urandom % 6) == 0;
         raw_rs = ($urandom % 23) == 0;
         flag_clr = 3'($urandom);
         rshort_clr = ($urandom % 3) == 0;
         user_src = 2'($urandom);
         step(1);
      end
      raw_lf = 1'b0; raw_hf = 1'b0; raw_ro = 1'b0; raw_rs = 1'b0;
      flag_clr = '0; rshort_clr = 1'b0;
      step(4);
      finish_run();
   end
endmodule